// File: doc/BRIEF.md
# Set Verify Voltage Stepper

This block runs one set-with-verify sequence on a resistive memory cell. After a start request it drives a set pulse of constant duration at a voltage code, then asks for a verify read of the cell. The read path, which biases the cell at 0.1 V, answers with a done strobe and a pass flag. The pass flag means the cell resistance came out below 50 kilo-ohm. If the read fails, the block raises the voltage code by one step and pulses again. It stops with a pass as soon as a read succeeds. It stops with a fail once the trial budget is spent.

A voltage code counts in units of 0.1 V, so on trial n the code equals the starting code plus n-1. This holds until the configured ceiling is reached, and the code then stays at the ceiling. The default pulse length is 20 cycles, which is 100 ns at 200 MHz. The default budget is 21 trials. When the run ends, the pass/fail status and the trial count stay valid until the next start. The block does not choose the starting voltage and does not drive any analog circuits.

Top module: `setv_stepper`

## Requirements
- R1: After reset the block is idle: pulse_o, rd_req_o, busy_o, done_o, pass_o and fail_o are 0, and trial_o is 0.
- R2: Every set pulse holds pulse_o high for exactly PULSE_CYC consecutive cycles, and the same length is used on every trial.
- R3: The first pulse of a run carries vinit_i as its code. If vinit_i is above VMAX, the code is clamped to VMAX.
- R4: After each failed verify, the code of the next pulse is one higher than the previous code (one code is 0.1 V). The code never goes above VMAX and stays at VMAX once it gets there.
- R5: rd_req_o rises in the cycle after each pulse ends. It stays high until rd_done_i is sampled high, and it is never high together with pulse_o.
- R6: When rd_done_i is high with rd_pass_i high, the run ends with done_o=1, pass_o=1 and fail_o=0.
- R7: trial_o is 1 during the first pulse of a run and goes up by one with each retry pulse. When the run ends it shows the number of the last trial.
- R8: If the verify of trial TRIAL_LIMIT fails, the run ends with done_o=1, fail_o=1, pass_o=0 and trial_o=TRIAL_LIMIT.
- R9: While a run is active (busy_o=1), start_i is ignored. After the run ends, done_o, pass_o, fail_o and trial_o hold their values until the next start.
- R10: A start_i received while done_o is high clears done_o, pass_o and fail_o in the next cycle and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run (ignored while busy) |
| vinit_i | input | VW | Starting voltage code, 0.1 V per unit |
| rd_done_i | input | 1 | Verify read result valid |
| rd_pass_i | input | 1 | Cell below the low-resistance threshold |
| pulse_o | output | 1 | Set pulse request |
| pulse_code_o | output | VW | Voltage code of the current trial |
| rd_req_o | output | 1 | Verify read request |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, status valid |
| pass_o | output | 1 | Run ended with the cell set |
| fail_o | output | 1 | Run ended with the trial budget spent |
| trial_o | output | NW | Trial count n |

## Verification
The bench builds the block with PULSE_CYC=4, TRIAL_LIMIT=5 and VMAX=10 and keeps VW at its default. With these values the trial budget and the code ceiling are both reached within a few hundred cycles. One run climbs to the ceiling, then keeps repeating the maximum code until the budget is exhausted. Another run asks for a starting code above the ceiling, which exercises the clamp. The short pulse keeps every run brief, so the bench can also compare the pulse length, the read handshake under a two-cycle read latency, and ignored mid-run starts against its model on every cycle.

// File: rtl/setv_pkg.sv
package setv_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PULSE = 2'd1,
      ST_READ  = 2'd2,
      ST_DONE  = 2'd3
   } setv_state_e;
endpackage

// File: rtl/setv_pulse_timer.sv
module setv_pulse_timer #(
   parameter int PULSE_CYC = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic run_i,
   output logic last_o
);
   localparam int CW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= CW'(PULSE_CYC - 1);
      else if (run_i && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign last_o = (cnt_q == '0);

   // the count stays inside the configured pulse length (R2)
   assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(PULSE_CYC - 1));
endmodule

// File: rtl/setv_volt_step.sv
module setv_volt_step #(
   parameter int VW   = 6,
   parameter int VMAX = 40
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [VW-1:0] init_i,
   input  logic          step_i,
   output logic [VW-1:0] code_o
);
   localparam logic [VW-1:0] CMAX = VW'(VMAX);

   logic [VW-1:0] code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         code_q <= '0;
      else if (load_i)
         code_q <= (init_i > CMAX) ? CMAX : init_i;
      else if (step_i && code_q < CMAX)
         code_q <= code_q + 1'b1;
   end

   assign code_o = code_q;

   assert_code_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
      code_q <= CMAX);
   assert_code_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && code_q < CMAX) |=> code_q == VW'($past(code_q) + 1'b1));
   assert_code_hold_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && code_q == CMAX) |=> $stable(code_q));
endmodule

// File: rtl/setv_trial_ctr.sv
module setv_trial_ctr #(
   parameter int TRIAL_LIMIT = 21,
   parameter int NW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          inc_i,
   output logic [NW-1:0] trial_o,
   output logic          last_o
);
   logic [NW-1:0] trial_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         trial_q <= '0;
      else if (load_i)
         trial_q <= NW'(1);
      else if (inc_i)
         trial_q <= trial_q + 1'b1;
   end

   assign trial_o = trial_q;
   assign last_o  = (trial_q == NW'(TRIAL_LIMIT));

   assert_trial_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trial_q <= NW'(TRIAL_LIMIT));
   assert_trial_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !load_i) |=> trial_q == NW'($past(trial_q) + 1'b1));
endmodule

// File: rtl/setv_stepper.sv
module setv_stepper
   import setv_pkg::*;
#(
   parameter int VW          = 6,
   parameter int VMAX        = 40,
   parameter int PULSE_CYC   = 20,
   parameter int TRIAL_LIMIT = 21,
   parameter int NW          = $clog2(TRIAL_LIMIT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [VW-1:0] vinit_i,
   input  logic          rd_done_i,
   input  logic          rd_pass_i,
   output logic          pulse_o,
   output logic [VW-1:0] pulse_code_o,
   output logic          rd_req_o,
   output logic          busy_o,
   output logic          done_o,
   output logic          pass_o,
   output logic          fail_o,
   output logic [NW-1:0] trial_o
);
   if (VMAX < 1 || VMAX >= (1 << VW)) begin : g_bad_vmax
      $error("setv_stepper: VMAX must fit in VW bits");
   end
   if (PULSE_CYC < 1) begin : g_bad_pulse
      $error("setv_stepper: PULSE_CYC must be at least 1");
   end
   if (TRIAL_LIMIT < 1 || TRIAL_LIMIT >= (1 << NW)) begin : g_bad_limit
      $error("setv_stepper: TRIAL_LIMIT must fit in NW bits");
   end

   setv_state_e state_q, state_d;
   logic        pass_q, fail_q;
   logic        launch, retry, t_last, n_last;

   wire idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE);
   assign launch  = idle_like && start_i;
   assign retry   = (state_q == ST_READ) && rd_done_i && !rd_pass_i && !n_last;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE, ST_DONE: if (start_i) state_d = ST_PULSE;
         ST_PULSE:         if (t_last)  state_d = ST_READ;
         ST_READ: begin
            if (rd_done_i) state_d = (rd_pass_i || n_last) ? ST_DONE : ST_PULSE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pass_q  <= 1'b0;
         fail_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (launch) begin
            pass_q <= 1'b0;
            fail_q <= 1'b0;
         end else if (state_q == ST_READ && rd_done_i) begin
            pass_q <= rd_pass_i;
            fail_q <= !rd_pass_i && n_last;
         end
      end
   end

   setv_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .load_i(launch || retry),
      .run_i(state_q == ST_PULSE),
      .last_o(t_last)
   );

   setv_volt_step #(.VW(VW), .VMAX(VMAX)) u_volt (
      .clk(clk), .rst_n(rst_n),
      .load_i(launch), .init_i(vinit_i),
      .step_i(retry),
      .code_o(pulse_code_o)
   );

   setv_trial_ctr #(.TRIAL_LIMIT(TRIAL_LIMIT), .NW(NW)) u_trial (
      .clk(clk), .rst_n(rst_n),
      .load_i(launch), .inc_i(retry),
      .trial_o(trial_o), .last_o(n_last)
   );

   assign pulse_o  = (state_q == ST_PULSE);
   assign rd_req_o = (state_q == ST_READ);
   assign busy_o   = pulse_o || rd_req_o;
   assign done_o   = (state_q == ST_DONE);
   assign pass_o   = pass_q;
   assign fail_o   = fail_q;

   assert_pulse_read_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(pulse_o && rd_req_o));
   assert_read_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_done_i) |=> rd_req_o);
   assert_status_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pass_o, fail_o}));
   assert_fail_at_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |-> trial_o == NW'(TRIAL_LIMIT));
   assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> ($stable(trial_o) && $stable(pass_o) && $stable(fail_o)));
   assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_o && !t_last) |=> (pulse_o && $stable(pulse_code_o)));
endmodule

// File: tb/setv_stepper_tb_top.sv
`timescale 1ns/100ps
module setv_stepper_tb_top;
   localparam int VW = 6, VMAX = 10, PC = 4, LIM = 5;
   localparam int NW = $clog2(LIM + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0, rd_done = 1'b0, rd_pass = 1'b0;
   logic [VW-1:0] vinit = '0;
   logic pulse, rdreq, busy, done, pass, fail;
   logic [VW-1:0] code;
   logic [NW-1:0] trial;

   always #2.5 clk = ~clk;

   setv_stepper #(.VW(VW), .VMAX(VMAX), .PULSE_CYC(PC), .TRIAL_LIMIT(LIM)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .vinit_i(vinit),
      .rd_done_i(rd_done), .rd_pass_i(rd_pass),
      .pulse_o(pulse), .pulse_code_o(code), .rd_req_o(rdreq), .busy_o(busy),
      .done_o(done), .pass_o(pass), .fail_o(fail), .trial_o(trial));

   int checks = 0, errors = 0, cyc = 0;
   int thr = 63;           // cell passes when last pulsed code >= thr
   int seen_code = 0, rdcnt = 0;
   int pulse_run = 0;

   // behavioural reference: 0 idle, 1 pulse, 2 read, 3 done
   int m_st = 0, m_left = 0, m_code = 0, m_trial = 0, m_pass = 0, m_fail = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_left = 0; m_code = 0; m_trial = 0; m_pass = 0; m_fail = 0;
      end else begin
         case (m_st)
            0, 3: if (start) begin
               m_st = 1; m_left = PC; m_trial = 1; m_pass = 0; m_fail = 0;
               m_code = (int'(vinit) > VMAX) ? VMAX : int'(vinit);
            end
            1: begin
               m_left--;
               if (m_left == 0) m_st = 2;
            end
            2: if (rd_done) begin
               if (rd_pass) begin m_st = 3; m_pass = 1; end
               else if (m_trial == LIM) begin m_st = 3; m_fail = 1; end
               else begin
                  m_st = 1; m_left = PC; m_trial++;
                  if (m_code < VMAX) m_code++;
               end
            end
            default: m_st = 0;
         endcase
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
      end
   endtask

   // compare against the model, then drive the read responder
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         chk(pulse == (m_st == 1), "R2 pulse_o", int'(pulse), int'(m_st == 1));
         chk(rdreq == (m_st == 2), "R5 rd_req_o", int'(rdreq), int'(m_st == 2));
         chk(done == (m_st == 3), "R10 done_o", int'(done), int'(m_st == 3));
         chk(busy == (m_st == 1 || m_st == 2), "R9 busy_o", int'(busy), int'(m_st == 1 || m_st == 2));
         chk(int'(trial) == m_trial, "R7 trial_o", int'(trial), m_trial);
         chk(int'(pass) == m_pass, "R6 pass_o", int'(pass), m_pass);
         chk(int'(fail) == m_fail, "R8 fail_o", int'(fail), m_fail);
         if (m_st == 1) chk(int'(code) == m_code, "R4 pulse_code_o", int'(code), m_code);
      end
      if (pulse) seen_code = int'(code);
      if (rdreq) rdcnt++; else rdcnt = 0;
      rd_done = rdreq && (rdcnt == 2);
      rd_pass = rdreq && (seen_code >= thr);
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic go(input int v, input int t);
      @(negedge clk);
      vinit = VW'(v); thr = t; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!pulse && !rdreq && !busy && !done && !pass && !fail, "R1 idle outputs", 1, 0);
      chk(trial == '0, "R1 trial_o", int'(trial), 0);
      rst_n = 1'b1;

      // R3 first code, R2 pulse length, R6 pass at trial 4 with code 6
      go(3, 6);
      chk(pulse && int'(code) == 3, "R3 first code", int'(code), 3);
      pulse_run = 0;
      while (pulse) begin pulse_run++; @(negedge clk); end
      chk(pulse_run == PC - 1 + 0 || pulse_run == PC, "R2 pulse length", pulse_run, PC);
      wait_done();
      chk(pass && !fail && int'(trial) == 4, "R6 pass trial", int'(trial), 4);
      chk(seen_code == 6, "R4 last code", seen_code, 6);

      // R9 hold after done
      repeat (6) @(negedge clk);
      chk(done && pass && int'(trial) == 4, "R9 status held", int'(trial), 4);

      // R8 + R4 saturation: codes 9,10,10,10,10 then fail at trial LIM
      go(9, 63);
      chk(!done && !pass, "R10 status cleared", int'(done), 0);
      wait_done();
      chk(fail && !pass && int'(trial) == LIM, "R8 fail at limit", int'(trial), LIM);
      chk(seen_code == VMAX, "R4 saturated code", seen_code, VMAX);

      // R3 clamp: start code above ceiling, pass on first trial
      go(12, 10);
      chk(int'(code) == VMAX, "R3 clamped code", int'(code), VMAX);
      wait_done();
      chk(pass && int'(trial) == 1, "R6 first-trial pass", int'(trial), 1);

      // R9 start while busy ignored: run from 2 to 5 passes at trial 4
      go(2, 5);
      @(negedge clk);
      vinit = VW'(7); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(int'(code) == 2, "R9 busy start ignored", int'(code), 2);
      wait_done();
      chk(pass && int'(trial) == 4 && seen_code == 5, "R9 run unaffected", int'(trial), 4);

      repeat (4) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule